// File: doc/BRIEF.md
# Core Idle State Controller

This block follows the idle condition of a single processor core that carries four hardware threads. Each thread signals halt and wake with one-cycle request pulses, and the block keeps one halted flag per thread. It moves the core among three power states: running (C0), a light idle state in which the core clock is gated (C1), and a deep idle state in which the core is power gated as well (C6). It drives the clock-gate and power-gate enables that the power switches use, and it reports the current state as a two-bit code.

The light state needs every thread halted. The deep state is reached only from the light state, and two checks must pass in the same cycle. The first is that the estimated distance to the next interrupt exceeds a programmable threshold. The second is that a running average of past light-idle lengths exceeds a second programmable threshold. The block keeps this average as an exponentially weighted moving average and updates it each time the core leaves C1. When the core leaves C6, it releases the power gate first and waits a fixed restore period with the clock still gated before it returns to C0. This makes the deep exit slower than the light exit. Three saturating counters record how many clock ticks the core spends in each state code.

Top module: `core_idle_ctrl`

## Requirements
- R1: During and after a synchronous reset, the state code is 2'b00, both gate enables are 0, the idle estimate is 0 and all three residency counters are 0.
- R2: While at least one of the four halted flags is clear, the core stays in C0 (code 2'b00) with the clock-gate enable at 0.
- R3: A thread's halted flag is set by its halt pulse and cleared by its wake pulse, and wake wins when both arrive in the same cycle. An interrupt request pulse clears all four flags.
- R4: Two clock edges after the pulse that halts the last running thread, the state code reads 2'b01 (C1), the clock-gate enable is 1 and the power-gate enable is 0.
- R5: C1 moves to C6 (code 2'b10, both enables 1) on the next edge only if the interrupt distance is strictly greater than its threshold and the idle estimate is strictly greater than its threshold. If either comparison fails, including equality, the core stays in C1.
- R6: A wake or interrupt request returns C1 to C0 two edges after the request. From C6, the power gate drops two edges after the request. The clock gate then stays at 1 with the code still 2'b10 for exactly RESTORE_CYC cycles, after which the code reads 2'b00 and the clock gate drops.
- R7: On every exit from C1, the estimate becomes E + (L >> AVG_SHIFT) - (E >> AVG_SHIFT), where E is the old estimate and L is the number of cycles the code read 2'b01. At all other times the estimate holds its value.
- R8: At each clock edge with tick high, the counter of the present state code increments (res_c0 for 2'b00, res_c1 for 2'b01, res_c6 for 2'b10, restore period included). The other two counters hold, and a counter at all ones stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Residency time base, counts when high at an edge |
| halt_req | input | THREADS | Per-thread halt pulse |
| wake_req | input | THREADS | Per-thread wake pulse |
| irq_req | input | 1 | Interrupt request pulse, wakes all threads |
| irq_dist | input | IRQ_W | Estimated cycles until the next interrupt |
| irq_thresh | input | IRQ_W | Minimum interrupt distance for deep entry |
| hist_thresh | input | AVG_W | Minimum idle estimate for deep entry |
| clk_gate_en | output | 1 | Core clock gate enable |
| pwr_gate_en | output | 1 | Core power gate enable |
| state_code | output | 2 | 00 C0, 01 C1, 10 C6 |
| idle_est | output | AVG_W | Moving average of light idle length |
| res_c0 | output | CNT_W | Ticks spent in C0 |
| res_c1 | output | CNT_W | Ticks spent in C1 |
| res_c6 | output | CNT_W | Ticks spent in C6 |

## Verification
The assertions assume that halt, wake and interrupt requests are single-cycle pulses. They also assume that the two thresholds and the interrupt distance stay steady while the core is in C1, so that the deep-entry check compares the values that were present at the deciding edge. The bench meets these assumptions. It changes thresholds and distances only while the core is in C0, and it drives every request for exactly one cycle, starting and ending on falling edges.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;

  typedef enum logic [1:0] {
    ST_ACT     = 2'b00,
    ST_LIGHT   = 2'b01,
    ST_DEEP    = 2'b10,
    ST_RESTORE = 2'b11
  } cstate_e;

  localparam logic [1:0] CODE_C0 = 2'b00;
  localparam logic [1:0] CODE_C1 = 2'b01;
  localparam logic [1:0] CODE_C6 = 2'b10;

  // restore window is still reported as deep idle
  function automatic logic [1:0] code_of(cstate_e s);
    case (s)
      ST_ACT:   return CODE_C0;
      ST_LIGHT: return CODE_C1;
      default:  return CODE_C6;
    endcase
  endfunction

endpackage

// File: rtl/core_idle_halt_track.sv
module core_idle_halt_track #(
  parameter int THREADS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [THREADS-1:0] halt_req,
  input  logic [THREADS-1:0] wake_req,
  input  logic               irq_req,
  output logic               all_halted
);

  logic [THREADS-1:0] halted_q;

  always_ff @(posedge clk) begin
    if (rst)          halted_q <= '0;
    else if (irq_req) halted_q <= '0;
    else              halted_q <= (halted_q | halt_req) & ~wake_req;
  end

  assign all_halted = &halted_q;

  assert_wake_wins_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((halted_q & $past(wake_req)) == '0));

  assert_irq_clears_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> (halted_q == '0));

endmodule

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
  import core_idle_pkg::*;
#(
  parameter int RESTORE_CYC = 8,
  parameter int IRQ_W       = 16,
  parameter int AVG_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             all_halted,
  input  logic [IRQ_W-1:0] irq_dist,
  input  logic [IRQ_W-1:0] irq_thresh,
  input  logic [AVG_W-1:0] est,
  input  logic [AVG_W-1:0] hist_thresh,
  output cstate_e          state_q,
  output logic             light_exit,
  output logic             clk_gate_en,
  output logic             pwr_gate_en
);

  localparam int RC_W = (RESTORE_CYC > 1) ? $clog2(RESTORE_CYC) : 1;
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RESTORE_CYC - 1);

  cstate_e         state_d;
  logic [RC_W-1:0] rcnt_q;
  logic            deep_ok;

  assign deep_ok = (irq_dist > irq_thresh) && (est > hist_thresh);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACT:     if (all_halted) state_d = ST_LIGHT;
      ST_LIGHT: begin
        if (!all_halted)  state_d = ST_ACT;
        else if (deep_ok) state_d = ST_DEEP;
      end
      ST_DEEP:    if (!all_halted) state_d = ST_RESTORE;
      ST_RESTORE: if (rcnt_q == '0) state_d = ST_ACT;
      default:    state_d = ST_ACT;
    endcase
  end

  assign light_exit = (state_q == ST_LIGHT) && (state_d != ST_LIGHT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ACT;
      rcnt_q      <= '0;
      clk_gate_en <= 1'b0;
      pwr_gate_en <= 1'b0;
    end else begin
      state_q     <= state_d;
      clk_gate_en <= (state_d != ST_ACT);
      pwr_gate_en <= (state_d == ST_DEEP);
      if (state_q != ST_RESTORE && state_d == ST_RESTORE) rcnt_q <= RC_LOAD;
      else if (state_q == ST_RESTORE && rcnt_q != '0)     rcnt_q <= rcnt_q - 1'b1;
    end
  end

  assert_pwr_implies_clk_R5: assert property (@(posedge clk) disable iff (rst)
    pwr_gate_en |-> clk_gate_en);

  assert_deep_entry_checks_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_gate_en) |-> ($past(irq_dist > irq_thresh) && $past(est > hist_thresh)
                            && $past(state_q == ST_LIGHT)));

  assert_light_needs_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LIGHT) |-> $past(all_halted));

  assert_active_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACT && !all_halted) |=> (state_q == ST_ACT && !clk_gate_en));

  assert_restore_gates_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESTORE) |-> (clk_gate_en && !pwr_gate_en));

endmodule

// File: rtl/core_idle_hist.sv
module core_idle_hist #(
  parameter int AVG_W     = 16,
  parameter int AVG_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_light,
  input  logic             light_exit,
  output logic [AVG_W-1:0] est_q
);

  localparam logic [AVG_W-1:0] LEN_MAX = '1;

  logic [AVG_W-1:0] len_q;
  logic [AVG_W-1:0] len_tot;
  logic [AVG_W-1:0] est_d;

  assign len_tot = (len_q == LEN_MAX) ? LEN_MAX : len_q + 1'b1;
  // cannot overflow: est - est/2^s + len/2^s stays within the width
  assign est_d   = est_q + (len_tot >> AVG_SHIFT) - (est_q >> AVG_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      est_q <= '0;
    end else begin
      if (!in_light)             len_q <= '0;
      else if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
      if (light_exit) est_q <= est_d;
    end
  end

  assert_est_only_on_exit_R7: assert property (@(posedge clk) disable iff (rst)
    !light_exit |=> $stable(est_q));

endmodule

// File: rtl/core_idle_resid.sv
module core_idle_resid #(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic [1:0]            code,
  output logic [2:0][CNT_W-1:0] cnt_q
);

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt_q[g] <= '0;
      else if (tick && code == 2'(g) && cnt_q[g] != '1) cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[g] == '1) |=> (cnt_q[g] == '1));

    assert_other_state_holds_R8: assert property (@(posedge clk) disable iff (rst)
      (code != 2'(g)) |=> $stable(cnt_q[g]));
  end

endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
  import core_idle_pkg::*;
#(
  parameter int THREADS     = 4,
  parameter int IRQ_W       = 16,
  parameter int AVG_W       = 16,
  parameter int AVG_SHIFT   = 2,
  parameter int RESTORE_CYC = 8,
  parameter int CNT_W       = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [THREADS-1:0] halt_req,
  input  logic [THREADS-1:0] wake_req,
  input  logic               irq_req,
  input  logic [IRQ_W-1:0]   irq_dist,
  input  logic [IRQ_W-1:0]   irq_thresh,
  input  logic [AVG_W-1:0]   hist_thresh,
  output logic               clk_gate_en,
  output logic               pwr_gate_en,
  output logic [1:0]         state_code,
  output logic [AVG_W-1:0]   idle_est,
  output logic [CNT_W-1:0]   res_c0,
  output logic [CNT_W-1:0]   res_c1,
  output logic [CNT_W-1:0]   res_c6
);

  logic                  all_halted;
  logic                  light_exit;
  cstate_e               state_q;
  logic [2:0][CNT_W-1:0] cnt;

  core_idle_halt_track #(.THREADS(THREADS)) u_halt (
    .clk(clk), .rst(rst), .halt_req(halt_req), .wake_req(wake_req),
    .irq_req(irq_req), .all_halted(all_halted)
  );

  core_idle_fsm #(.RESTORE_CYC(RESTORE_CYC), .IRQ_W(IRQ_W), .AVG_W(AVG_W)) u_fsm (
    .clk(clk), .rst(rst), .all_halted(all_halted), .irq_dist(irq_dist),
    .irq_thresh(irq_thresh), .est(idle_est), .hist_thresh(hist_thresh),
    .state_q(state_q), .light_exit(light_exit),
    .clk_gate_en(clk_gate_en), .pwr_gate_en(pwr_gate_en)
  );

  core_idle_hist #(.AVG_W(AVG_W), .AVG_SHIFT(AVG_SHIFT)) u_hist (
    .clk(clk), .rst(rst), .in_light(state_q == ST_LIGHT),
    .light_exit(light_exit), .est_q(idle_est)
  );

  assign state_code = code_of(state_q);

  core_idle_resid #(.CNT_W(CNT_W)) u_resid (
    .clk(clk), .rst(rst), .tick(tick), .code(state_code), .cnt_q(cnt)
  );

  assign res_c0 = cnt[0];
  assign res_c1 = cnt[1];
  assign res_c6 = cnt[2];

endmodule

// File: tb/tb_core_idle_ctrl.sv
module tb_core_idle_ctrl;

  localparam int T     = 4;
  localparam int IW    = 12;
  localparam int AW    = 12;
  localparam int SH    = 2;
  localparam int RC    = 3;
  localparam int CW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [T-1:0] halt_req = '0;
  logic [T-1:0] wake_req = '0;
  logic irq_req = 1'b0;
  logic [IW-1:0] irq_dist = '0;
  logic [IW-1:0] irq_thresh = 12'd50;
  logic [AW-1:0] hist_thresh = 12'd20;
  logic clk_gate_en, pwr_gate_en;
  logic [1:0] state_code;
  logic [AW-1:0] idle_est;
  logic [CW-1:0] res_c0, res_c1, res_c6;

  int total = 0;
  int bad   = 0;
  int e_est = 0;

  always #4 clk = ~clk;

  core_idle_ctrl #(.THREADS(T), .IRQ_W(IW), .AVG_W(AW), .AVG_SHIFT(SH),
                   .RESTORE_CYC(RC), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .tick(tick), .halt_req(halt_req), .wake_req(wake_req),
    .irq_req(irq_req), .irq_dist(irq_dist), .irq_thresh(irq_thresh),
    .hist_thresh(hist_thresh), .clk_gate_en(clk_gate_en), .pwr_gate_en(pwr_gate_en),
    .state_code(state_code), .idle_est(idle_est), .res_c0(res_c0),
    .res_c1(res_c1), .res_c6(res_c6)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ewma(input int e, input int l);
    return e + (l >> SH) - (e >> SH);
  endfunction

  task automatic pulse_halt(input logic [T-1:0] m);
    halt_req = m; @(negedge clk); halt_req = '0;
  endtask

  task automatic pulse_wake(input logic [T-1:0] m);
    wake_req = m; @(negedge clk); wake_req = '0;
  endtask

  task automatic pulse_irq();
    irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; repeat (n) @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 state", state_code, 0);
    chk("R1 clk_gate", clk_gate_en, 0);
    chk("R1 pwr_gate", pwr_gate_en, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 est", idle_est, 0);
    chk("R1 c0", res_c0, 0);
    chk("R1 c1", res_c1, 0);
    chk("R1 c6", res_c6, 0);

    // R2 sweep of every partial halt mask
    for (int m = 0; m < 15; m++) begin
      pulse_halt(4'(m));
      repeat (2) @(negedge clk);
      chk("R2 state partial", state_code, 0);
      chk("R2 clk_gate partial", clk_gate_en, 0);
      pulse_wake(4'hF);
      @(negedge clk);
    end

    // R3 wake wins over a same-cycle halt on thread 0
    halt_req = 4'hF; wake_req = 4'h1;
    @(negedge clk);
    halt_req = '0; wake_req = '0;
    repeat (2) @(negedge clk);
    chk("R3 wake wins", state_code, 0);
    pulse_halt(4'h1);
    @(negedge clk);
    chk("R3 others kept halted", state_code, 1);
    // R6 interrupt exit from C1, L=2
    pulse_irq();
    chk("R6 still C1 one edge after irq", state_code, 1);
    @(negedge clk);
    chk("R6 irq exit to C0", state_code, 0);
    e_est = ewma(e_est, 2);
    chk("R7 est after L=2", idle_est, 12'(e_est));
    pulse_halt(4'hE);
    repeat (2) @(negedge clk);
    chk("R3 irq cleared all flags", state_code, 0);
    pulse_wake(4'hF);
    @(negedge clk);

    // R4 light entry, long residency (L=100), deep blocked
    irq_dist = 12'd10;
    pulse_halt(4'hF);
    chk("R4 not yet C1", state_code, 0);
    @(negedge clk);
    chk("R4 state C1", state_code, 1);
    chk("R4 clk_gate", clk_gate_en, 1);
    chk("R4 pwr_gate", pwr_gate_en, 0);
    repeat (98) @(negedge clk);
    chk("R5 stays C1 est low", state_code, 1);
    pulse_wake(4'h8);
    @(negedge clk);
    e_est = ewma(e_est, 100);
    chk("R6 wake exit C0", state_code, 0);
    chk("R6 clk_gate released", clk_gate_en, 0);
    chk("R7 est after L=100", idle_est, 12'(e_est));

    // R5 interrupt distance equal to threshold blocks deep (L=8)
    irq_dist = 12'd50;
    pulse_halt(4'h8);
    @(negedge clk);
    chk("R5 C1 at equal dist", state_code, 1);
    repeat (6) @(negedge clk);
    chk("R5 no deep at equal dist", state_code, 1);
    chk("R5 pwr off at equal dist", pwr_gate_en, 0);
    pulse_irq();
    @(negedge clk);
    e_est = ewma(e_est, 8);
    chk("R7 est after L=8", idle_est, 12'(e_est));

    // R5 both checks pass: deep after one cycle in C1 (L=1)
    irq_dist = 12'd51;
    pulse_halt(4'hF);
    @(negedge clk);
    chk("R5 C1 before deep", state_code, 1);
    @(negedge clk);
    e_est = ewma(e_est, 1);
    chk("R5 state C6", state_code, 2);
    chk("R5 pwr_gate", pwr_gate_en, 1);
    chk("R5 clk_gate in C6", clk_gate_en, 1);
    chk("R7 est after L=1", idle_est, 12'(e_est));
    repeat (4) @(negedge clk);
    // R6 deep exit sequence
    pulse_wake(4'h2);
    chk("R6 pwr still on", pwr_gate_en, 1);
    @(negedge clk);
    chk("R6 pwr released", pwr_gate_en, 0);
    chk("R6 clk held in restore", clk_gate_en, 1);
    chk("R6 code in restore", state_code, 2);
    for (int i = 1; i < RC; i++) begin
      @(negedge clk);
      chk("R6 restore clk", clk_gate_en, 1);
      chk("R6 restore pwr", pwr_gate_en, 0);
      chk("R6 restore code", state_code, 2);
    end
    @(negedge clk);
    chk("R6 C0 after restore", state_code, 0);
    chk("R6 clk ungated after restore", clk_gate_en, 0);
    pulse_wake(4'hF);
    @(negedge clk);

    // R5 history check fails (est below threshold), L=4
    pulse_halt(4'hF);
    @(negedge clk);
    @(negedge clk);
    chk("R5 no deep est low", state_code, 1);
    chk("R5 pwr off est low", pwr_gate_en, 0);
    @(negedge clk);
    pulse_wake(4'hF);
    @(negedge clk);
    e_est = ewma(e_est, 4);
    chk("R7 est after L=4", idle_est, 12'(e_est));

    // R8 residency counting per state
    irq_dist = 12'd0;
    ticks(10);
    chk("R8 c0 count", res_c0, 10);
    pulse_halt(4'hF);
    @(negedge clk);
    ticks(7);
    pulse_wake(4'h4);
    @(negedge clk);
    e_est = ewma(e_est, 9);
    chk("R8 c1 count", res_c1, 7);
    chk("R8 c0 held in C1", res_c0, 10);
    chk("R7 est after L=9", idle_est, 12'(e_est));
    hist_thresh = 12'd0;
    irq_dist = 12'd51;
    pulse_halt(4'h4);
    @(negedge clk);
    @(negedge clk);
    chk("R5 deep for count", state_code, 2);
    ticks(5);
    pulse_wake(4'h1);
    @(negedge clk);
    ticks(RC);
    chk("R8 back to C0", state_code, 0);
    chk("R8 c6 includes restore", res_c6, 5 + RC);
    chk("R8 c1 held", res_c1, 7);
    chk("R8 c0 held", res_c0, 10);
    pulse_wake(4'hF);
    @(negedge clk);
    ticks(300);
    chk("R8 c0 saturated", res_c0, 255);
    chk("R8 c6 held at sat", res_c6, 5 + RC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule